// File: doc/BRIEF.md
# Paged NIC Control Register File

This block is the host-facing register bank of a classic paged Ethernet controller. The host reaches it through a 5-bit offset plus a one-cycle access strobe that carries a read/write flag. Offset 0 always addresses the command register. Offsets 1 to 15 are decoded according to a page number held in the top two command bits. Many offsets are one-directional, so a read and a write of the same offset can reach two unrelated registers.

The bank holds the following state:
- the receive ring start, stop and boundary pages;
- the transmit page and byte count;
- the remote start address and remote byte count;
- the local DMA address;
- the next-packet pointers and the address counter;
- the receive, transmit and data configuration bytes;
- the interrupt status and interrupt mask;
- the station address and the multicast filter.

A command write also has immediate side effects. It can clear the reset-complete flag, flag an empty remote transfer as complete, and complete a transmit request. A level interrupt output is high whenever an enabled status bit below bit 7 is set. Frame movement is outside this block.

Top module: `nic_regbank`

## Requirements
- R1: The page is command bits 7:6. Offset 0 reads and writes the whole command byte on every page. The command register resets to 0x22.
- R2: On page 0, writes to offsets 1 and 2 set the ring start page and ring stop page, and reads of those offsets return the low and high bytes of the local DMA address. On page 2 it is the other way round: writes to offsets 1 and 2 set the local DMA address low and high bytes, and reads return the ring start and stop pages.
- R3: The 16-bit remote start address (page 0, offsets 8 low and 9 high), remote byte count (page 0, offsets 10 low and 11 high) and transmit count (page 0, offsets 5 low and 6 high) are written one byte at a time. Each write replaces only its own half.
- R4: A write to interrupt status (page 0, offset 7) clears each status bit in 6:0 whose written bit is 1. Status bit 7 is never changed by such a write.
- R5: The interrupt output is high exactly when (status AND mask AND 0x7F) is nonzero. It follows a status or mask change on the cycle after the write. The mask is written at page 0, offset 15.
- R6: After reset:
  - status is 0x80 and the mask is 0x00;
  - all eight multicast filter bytes are 0xFF;
  - every other register is 0x00.
- R7: A command write whose bit 0 (stop) is 0 clears status bit 7 (reset complete). A command write with bit 0 set causes no side effect.
- R8: A command write with bit 0 clear and bit 3 or bit 4 set, made while the remote byte count is zero, sets status bit 6.
- R9: A command write with bit 0 clear and bit 2 set has four effects:
  - the stored command byte has bit 2 cleared;
  - transmit status becomes 0x01 (page 0, offset 4 read);
  - status bit 1 is set;
  - the interrupt output is updated.
- R10: The remaining registers are reached as follows:
  - Page 1: offsets 1 to 6 are the station address bytes, offset 7 is the current receive page, and offsets 8 to 15 are the multicast filter. All of them can be read and written.
  - Page 0 writes: offset 3 is the boundary page, 4 the transmit page, 12 receive configuration, 13 transmit configuration and 14 data configuration.
  - Page 0 reads: offset 3 is the boundary page, 4 transmit status, 7 interrupt status, and 8 and 9 the remote start address.
  - Page 2 reads: offset 3 is the remote next pointer, 4 the transmit page, 5 the local next pointer, 6 and 7 the address counter, and 12 to 15 the receive, transmit and data configuration and the mask.
  - Page 2 writes: offsets 3, 5, 6 and 7 reach the registers that read back at those offsets.
- R11: A read of any offset not listed above returns 0x00. This covers all of page 3 and offsets 16 to 31. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accEn | input | 1 | Access strobe, one cycle per access |
| accWr | input | 1 | 1 = write, 0 = read |
| accOff | input | 5 | Register offset |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte, combinational from offset and page |
| irqOut | output | 1 | Level interrupt |

## Verification
A single command write can raise the remote-complete bit and the transmit-done bit on the same clock edge while also clearing the reset-complete bit. All of these updates must merge into one status value without one overwriting another. The bench provokes this with command 0x0E while the remote count is zero and the status is clear. It then expects a status read of 0x42, a command read of 0x0A with the transmit bit gone, and the interrupt high through the enabled bit 6. A second collision is a status write-clear landing on a bit that a command side effect set. This case is judged through explicit write-then-read sequences.

// File: rtl/nic_regbank_pkg.sv
package nic_regbank_pkg;
  localparam int BYTE_W = 8;

  // command bit positions
  localparam int CMD_STOP_BIT = 0;
  localparam int CMD_TX_BIT   = 2;
  localparam int CMD_RRD_BIT  = 3;
  localparam int CMD_RWR_BIT  = 4;

  // status bit positions
  localparam int ST_TXDONE_BIT = 1;
  localparam int ST_RDONE_BIT  = 6;
  localparam int ST_RESET_BIT  = 7;
  localparam logic [BYTE_W-1:0] ST_IRQ_MASK = 8'h7F;

  typedef struct packed {
    logic cmd;
    logic ringStart;
    logic ringStop;
    logic boundary;
    logic txPage;
    logic txCntLo;
    logic txCntHi;
    logic statClr;
    logic rAddrLo;
    logic rAddrHi;
    logic rCntLo;
    logic rCntHi;
    logic rxCfg;
    logic txCfg;
    logic dataCfg;
    logic intMask;
    logic macByte;
    logic curPage;
    logic mcastByte;
    logic ldmaLo;
    logic ldmaHi;
    logic rNext;
    logic lNext;
    logic acntLo;
    logic acntHi;
  } wrStrobe_t;

  typedef enum logic [4:0] {
    RD_NONE, RD_CMD, RD_LDMA_LO, RD_LDMA_HI, RD_BND, RD_TSR, RD_STAT,
    RD_RADDR_LO, RD_RADDR_HI, RD_MAC, RD_CURPG, RD_MCAST, RD_START,
    RD_STOP, RD_RNEXT, RD_TXPG, RD_LNEXT, RD_ACNT_LO, RD_ACNT_HI,
    RD_RXCFG, RD_TXCFG, RD_DCFG, RD_IMR
  } rdSel_t;
endpackage

// File: rtl/nic_regbank_decode.sv
module nic_regbank_decode
  import nic_regbank_pkg::*;
#(
  parameter int OFF_W       = 5,
  parameter int MAC_BYTES   = 6,
  parameter int MCAST_BYTES = 8
) (
  input  logic             accEn,
  input  logic             accWr,
  input  logic [OFF_W-1:0] accOff,
  input  logic [1:0]       page,
  output wrStrobe_t        stb,
  output rdSel_t           rdSel
);
  localparam int REG_SPAN   = 16;
  localparam int MAC_BASE   = 1;
  localparam int MAC_LAST   = MAC_BASE + MAC_BYTES - 1;
  localparam int CURPG_OFF  = MAC_LAST + 1;
  localparam int MCAST_BASE = CURPG_OFF + 1;
  localparam int MCAST_LAST = MCAST_BASE + MCAST_BYTES - 1;

  logic       inWin;
  logic       wrEn;
  logic [3:0] lo;
  int         loInt;

  assign inWin = (int'(accOff) < REG_SPAN);
  assign wrEn  = accEn && accWr && inWin;
  assign lo    = accOff[3:0];
  assign loInt = int'(lo);

  always_comb begin
    stb   = '0;
    rdSel = RD_NONE;
    if (inWin) begin
      if (lo == 4'd0) begin
        stb.cmd = wrEn;
        rdSel   = RD_CMD;
      end else begin
        case (page)
          2'd0: begin
            case (lo)
              4'd1:  begin stb.ringStart = wrEn; rdSel = RD_LDMA_LO;  end
              4'd2:  begin stb.ringStop  = wrEn; rdSel = RD_LDMA_HI;  end
              4'd3:  begin stb.boundary  = wrEn; rdSel = RD_BND;      end
              4'd4:  begin stb.txPage    = wrEn; rdSel = RD_TSR;      end
              4'd5:  stb.txCntLo = wrEn;
              4'd6:  stb.txCntHi = wrEn;
              4'd7:  begin stb.statClr   = wrEn; rdSel = RD_STAT;     end
              4'd8:  begin stb.rAddrLo   = wrEn; rdSel = RD_RADDR_LO; end
              4'd9:  begin stb.rAddrHi   = wrEn; rdSel = RD_RADDR_HI; end
              4'd10: stb.rCntLo  = wrEn;
              4'd11: stb.rCntHi  = wrEn;
              4'd12: stb.rxCfg   = wrEn;
              4'd13: stb.txCfg   = wrEn;
              4'd14: stb.dataCfg = wrEn;
              4'd15: stb.intMask = wrEn;
              default: ;
            endcase
          end
          2'd1: begin
            if (loInt >= MAC_BASE && loInt <= MAC_LAST) begin
              stb.macByte = wrEn;
              rdSel       = RD_MAC;
            end else if (loInt == CURPG_OFF) begin
              stb.curPage = wrEn;
              rdSel       = RD_CURPG;
            end else if (loInt >= MCAST_BASE && loInt <= MCAST_LAST) begin
              stb.mcastByte = wrEn;
              rdSel         = RD_MCAST;
            end
          end
          2'd2: begin
            case (lo)
              4'd1:  begin stb.ldmaLo = wrEn; rdSel = RD_START;   end
              4'd2:  begin stb.ldmaHi = wrEn; rdSel = RD_STOP;    end
              4'd3:  begin stb.rNext  = wrEn; rdSel = RD_RNEXT;   end
              4'd4:  rdSel = RD_TXPG;
              4'd5:  begin stb.lNext  = wrEn; rdSel = RD_LNEXT;   end
              4'd6:  begin stb.acntLo = wrEn; rdSel = RD_ACNT_LO; end
              4'd7:  begin stb.acntHi = wrEn; rdSel = RD_ACNT_HI; end
              4'd12: rdSel = RD_RXCFG;
              4'd13: rdSel = RD_TXCFG;
              4'd14: rdSel = RD_DCFG;
              4'd15: rdSel = RD_IMR;
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/nic_regbank_regs.sv
module nic_regbank_regs
  import nic_regbank_pkg::*;
#(
  parameter int                OFF_W       = 5,
  parameter int                MAC_BYTES   = 6,
  parameter int                MCAST_BYTES = 8,
  parameter logic [BYTE_W-1:0] CMD_RST     = 8'h22,
  parameter logic [BYTE_W-1:0] STAT_RST    = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         stb,
  input  rdSel_t            rdSel,
  input  logic [OFF_W-1:0]  accOff,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic [1:0]        page,
  output logic              irqOut
);
  localparam int MAC_W      = (MAC_BYTES > 1) ? $clog2(MAC_BYTES) : 1;
  localparam int MC_W       = (MCAST_BYTES > 1) ? $clog2(MCAST_BYTES) : 1;
  localparam int MAC_BASE   = 1;
  localparam int MCAST_BASE = MAC_BASE + MAC_BYTES + 1;
  localparam int W2         = 2 * BYTE_W;

  logic [BYTE_W-1:0] cmdReg, statReg, statNext, imrReg, tsrReg;
  logic [BYTE_W-1:0] startPg, stopPg, bndPg, txPg, curPg, rNext, lNext;
  logic [BYTE_W-1:0] rxCfg, txCfg, dCfg;
  logic [W2-1:0]     txCnt, rAddr, rCnt, ldma, acnt;
  logic [BYTE_W-1:0] mac   [MAC_BYTES];
  logic [BYTE_W-1:0] mcast [MCAST_BYTES];
  logic [OFF_W-1:0]  macDiff, mcDiff;
  logic [MAC_W-1:0]  macIdx;
  logic [MC_W-1:0]   mcIdx;
  logic              cmdGo, txReq, dmaDone;

  assign macDiff = accOff - OFF_W'(MAC_BASE);
  assign mcDiff  = accOff - OFF_W'(MCAST_BASE);
  assign macIdx  = macDiff[MAC_W-1:0];
  assign mcIdx   = mcDiff[MC_W-1:0];
  assign page    = cmdReg[7:6];

  assign cmdGo   = stb.cmd && !wrData[CMD_STOP_BIT];
  assign txReq   = cmdGo && wrData[CMD_TX_BIT];
  assign dmaDone = cmdGo && (wrData[CMD_RRD_BIT] || wrData[CMD_RWR_BIT]) && (rCnt == '0);

  always_comb begin
    statNext = statReg;
    if (stb.statClr) statNext = statNext & ~(wrData & ST_IRQ_MASK);
    if (cmdGo)       statNext[ST_RESET_BIT]  = 1'b0;
    if (dmaDone)     statNext[ST_RDONE_BIT]  = 1'b1;
    if (txReq)       statNext[ST_TXDONE_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= CMD_RST;   statReg <= STAT_RST; imrReg <= '0; tsrReg <= '0;
      startPg <= '0; stopPg <= '0; bndPg <= '0; txPg <= '0; curPg <= '0;
      rNext <= '0; lNext <= '0; rxCfg <= '0; txCfg <= '0; dCfg <= '0;
      txCnt <= '0; rAddr <= '0; rCnt <= '0; ldma <= '0; acnt <= '0;
      for (int i = 0; i < MAC_BYTES; i++)   mac[i]   <= '0;
      for (int i = 0; i < MCAST_BYTES; i++) mcast[i] <= '1;
    end else begin
      statReg <= statNext;
      if (stb.cmd)       cmdReg <= txReq ? (wrData & ~(BYTE_W'(1) << CMD_TX_BIT)) : wrData;
      if (txReq)         tsrReg <= BYTE_W'(1);
      if (stb.ringStart) startPg <= wrData;
      if (stb.ringStop)  stopPg  <= wrData;
      if (stb.boundary)  bndPg   <= wrData;
      if (stb.txPage)    txPg    <= wrData;
      if (stb.txCntLo)   txCnt[BYTE_W-1:0]  <= wrData;
      if (stb.txCntHi)   txCnt[W2-1:BYTE_W] <= wrData;
      if (stb.rAddrLo)   rAddr[BYTE_W-1:0]  <= wrData;
      if (stb.rAddrHi)   rAddr[W2-1:BYTE_W] <= wrData;
      if (stb.rCntLo)    rCnt[BYTE_W-1:0]   <= wrData;
      if (stb.rCntHi)    rCnt[W2-1:BYTE_W]  <= wrData;
      if (stb.rxCfg)     rxCfg  <= wrData;
      if (stb.txCfg)     txCfg  <= wrData;
      if (stb.dataCfg)   dCfg   <= wrData;
      if (stb.intMask)   imrReg <= wrData;
      if (stb.macByte)   mac[macIdx]  <= wrData;
      if (stb.curPage)   curPg        <= wrData;
      if (stb.mcastByte) mcast[mcIdx] <= wrData;
      if (stb.ldmaLo)    ldma[BYTE_W-1:0]  <= wrData;
      if (stb.ldmaHi)    ldma[W2-1:BYTE_W] <= wrData;
      if (stb.rNext)     rNext <= wrData;
      if (stb.lNext)     lNext <= wrData;
      if (stb.acntLo)    acnt[BYTE_W-1:0]  <= wrData;
      if (stb.acntHi)    acnt[W2-1:BYTE_W] <= wrData;
    end
  end

  always_comb begin
    case (rdSel)
      RD_CMD:      rdData = cmdReg;
      RD_LDMA_LO:  rdData = ldma[BYTE_W-1:0];
      RD_LDMA_HI:  rdData = ldma[W2-1:BYTE_W];
      RD_BND:      rdData = bndPg;
      RD_TSR:      rdData = tsrReg;
      RD_STAT:     rdData = statReg;
      RD_RADDR_LO: rdData = rAddr[BYTE_W-1:0];
      RD_RADDR_HI: rdData = rAddr[W2-1:BYTE_W];
      RD_MAC:      rdData = mac[macIdx];
      RD_CURPG:    rdData = curPg;
      RD_MCAST:    rdData = mcast[mcIdx];
      RD_START:    rdData = startPg;
      RD_STOP:     rdData = stopPg;
      RD_RNEXT:    rdData = rNext;
      RD_TXPG:     rdData = txPg;
      RD_LNEXT:    rdData = lNext;
      RD_ACNT_LO:  rdData = acnt[BYTE_W-1:0];
      RD_ACNT_HI:  rdData = acnt[W2-1:BYTE_W];
      RD_RXCFG:    rdData = rxCfg;
      RD_TXCFG:    rdData = txCfg;
      RD_DCFG:     rdData = dCfg;
      RD_IMR:      rdData = imrReg;
      default:     rdData = '0;
    endcase
  end

  assign irqOut = |(statReg & imrReg & ST_IRQ_MASK);

  AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rstN)
    stb.statClr |=> ((statReg & $past(wrData & ST_IRQ_MASK)) == '0)); // R4
  AST_STAT_TOP_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.statClr |=> (statReg[ST_RESET_BIT] == $past(statReg[ST_RESET_BIT]))); // R4
  AST_START_CLEARS_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmd && !wrData[CMD_STOP_BIT]) |=> !statReg[ST_RESET_BIT]); // R7
  AST_EMPTY_DMA_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmd && !wrData[CMD_STOP_BIT] && (wrData[CMD_RRD_BIT] || wrData[CMD_RWR_BIT]) && (rCnt == '0))
      |=> statReg[ST_RDONE_BIT]); // R8
  AST_TX_COMPLETES: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmd && !wrData[CMD_STOP_BIT] && wrData[CMD_TX_BIT])
      |=> (!cmdReg[CMD_TX_BIT] && statReg[ST_TXDONE_BIT] && (tsrReg == BYTE_W'(1)))); // R9
  AST_STOPPED_CMD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmd && wrData[CMD_STOP_BIT]) |=> (statReg == $past(statReg))); // R7
endmodule

// File: rtl/nic_regbank.sv
module nic_regbank
  import nic_regbank_pkg::*;
#(
  parameter int                OFF_W       = 5,
  parameter int                MAC_BYTES   = 6,
  parameter int                MCAST_BYTES = 8,
  parameter logic [BYTE_W-1:0] CMD_RST     = 8'h22,
  parameter logic [BYTE_W-1:0] STAT_RST    = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accEn,
  input  logic              accWr,
  input  logic [OFF_W-1:0]  accOff,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              irqOut
);
  wrStrobe_t  stb;
  rdSel_t     rdSel;
  logic [1:0] page;

  nic_regbank_decode #(
    .OFF_W(OFF_W), .MAC_BYTES(MAC_BYTES), .MCAST_BYTES(MCAST_BYTES)
  ) uDecode (
    .accEn(accEn), .accWr(accWr), .accOff(accOff), .page(page),
    .stb(stb), .rdSel(rdSel)
  );

  nic_regbank_regs #(
    .OFF_W(OFF_W), .MAC_BYTES(MAC_BYTES), .MCAST_BYTES(MCAST_BYTES),
    .CMD_RST(CMD_RST), .STAT_RST(STAT_RST)
  ) uRegs (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .accOff(accOff),
    .wrData(wrData), .rdData(rdData), .page(page), .irqOut(irqOut)
  );
endmodule

// File: tb/nic_regbank_test.sv
module nic_regbank_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       accEn = 1'b0;
  logic       accWr = 1'b0;
  logic [4:0] accOff = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irqOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #5 clk = ~clk;

  nic_regbank uut (
    .clk(clk), .rstN(rstN), .accEn(accEn), .accWr(accWr), .accOff(accOff),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  // monitor: compares every read against the scoreboard head
  always @(negedge clk) begin
    if (rstN && accEn && !accWr && expQ.size() > 0) begin
      logic [7:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (rdData !== e) begin
        errors++;
        $display("FAIL %s: off 0x%02h read 0x%02h expected 0x%02h", t, accOff, rdData, e);
      end
    end
  end

  task automatic wrReg(input logic [4:0] off, input logic [7:0] d);
    @(posedge clk); #1;
    accEn = 1'b1; accWr = 1'b1; accOff = off; wrData = d;
    @(posedge clk); #1;
    accEn = 1'b0; accWr = 1'b0;
  endtask

  task automatic rdExp(input logic [4:0] off, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    expQ.push_back(e); tagQ.push_back(t);
    accEn = 1'b1; accWr = 1'b0; accOff = off;
    @(posedge clk); #1;
    accEn = 1'b0;
  endtask

  task automatic chkIrq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irqOut !== e) begin
      errors++;
      $display("FAIL %s: irq %0b expected %0b", t, irqOut, e);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // reset state
    rdExp(5'd0, 8'h22, "R6 cmd reset");
    rdExp(5'd7, 8'h80, "R6 status reset");
    chkIrq(1'b0, "R6 irq reset");
    wrReg(5'd7, 8'hFF);
    rdExp(5'd7, 8'h80, "R4 bit7 survives clear");
    wrReg(5'd15, 8'h80);
    chkIrq(1'b0, "R5 bit7 never interrupts");
    wrReg(5'd15, 8'h00);

    // page 1
    wrReg(5'd0, 8'h61);
    rdExp(5'd0, 8'h61, "R1 cmd on page1");
    for (int i = 0; i < 8; i++) rdExp(5'(8 + i), 8'hFF, "R6 multicast reset");
    for (int i = 0; i < 6; i++) wrReg(5'(1 + i), 8'(8'h10 + i));
    for (int i = 0; i < 6; i++) rdExp(5'(1 + i), 8'(8'h10 + i), "R10 station addr");
    wrReg(5'd7, 8'h4C);
    rdExp(5'd7, 8'h4C, "R10 current page");
    wrReg(5'd9, 8'h3E);
    rdExp(5'd9, 8'h3E, "R10 multicast byte");

    // page 2 writes
    wrReg(5'd0, 8'hA1);
    wrReg(5'd1, 8'h34); wrReg(5'd2, 8'h12);
    wrReg(5'd3, 8'h5A); wrReg(5'd5, 8'h6B);
    wrReg(5'd6, 8'hCD); wrReg(5'd7, 8'hAB);
    rdExp(5'd3, 8'h5A, "R10 remote next");
    rdExp(5'd5, 8'h6B, "R10 local next");
    rdExp(5'd6, 8'hCD, "R10 addr counter lo");
    rdExp(5'd7, 8'hAB, "R10 addr counter hi");
    rdExp(5'd15, 8'h00, "R6 mask reset");

    // page 0 direction-split offsets
    wrReg(5'd0, 8'h21);
    wrReg(5'd1, 8'h40); wrReg(5'd2, 8'h80);
    rdExp(5'd1, 8'h34, "R2 local dma lo");
    rdExp(5'd2, 8'h12, "R2 local dma hi");
    wrReg(5'd3, 8'h47);
    rdExp(5'd3, 8'h47, "R10 boundary");
    wrReg(5'd4, 8'h50);
    wrReg(5'd12, 8'h0C); wrReg(5'd13, 8'h02); wrReg(5'd14, 8'h48);
    wrReg(5'd8, 8'hAA); wrReg(5'd9, 8'h55);
    rdExp(5'd8, 8'hAA, "R3 remote addr lo");
    rdExp(5'd9, 8'h55, "R3 remote addr hi");
    wrReg(5'd8, 8'h11);
    rdExp(5'd8, 8'h11, "R3 lo replaced");
    rdExp(5'd9, 8'h55, "R3 hi kept");
    wrReg(5'd10, 8'h00); wrReg(5'd11, 8'h01);
    wrReg(5'd20, 8'h5A);
    rdExp(5'd20, 8'h00, "R11 high offset");
    rdExp(5'd10, 8'h00, "R11 write-only offset");

    // page 2 readbacks
    wrReg(5'd0, 8'hA1);
    rdExp(5'd1, 8'h40, "R2 ring start");
    rdExp(5'd2, 8'h80, "R2 ring stop");
    rdExp(5'd4, 8'h50, "R10 tx page");
    rdExp(5'd12, 8'h0C, "R10 rx cfg");
    rdExp(5'd13, 8'h02, "R10 tx cfg");
    rdExp(5'd14, 8'h48, "R10 data cfg");

    // page 3 undecoded
    wrReg(5'd0, 8'hE1);
    wrReg(5'd1, 8'h99);
    rdExp(5'd1, 8'h00, "R11 page3 read");
    rdExp(5'd0, 8'hE1, "R1 cmd on page3");
    wrReg(5'd0, 8'hA1);
    rdExp(5'd1, 8'h40, "R11 page3 write ignored");

    // command side effects
    wrReg(5'd0, 8'h21);
    rdExp(5'd7, 8'h80, "R7 stopped cmd keeps bit7");
    wrReg(5'd0, 8'h02);
    rdExp(5'd7, 8'h00, "R7 start clears bit7");
    rdExp(5'd0, 8'h02, "R1 cmd readback");
    wrReg(5'd0, 8'h0A);
    rdExp(5'd7, 8'h00, "R8 nonzero count no done");
    wrReg(5'd11, 8'h00);
    wrReg(5'd0, 8'h0A);
    rdExp(5'd7, 8'h40, "R8 empty remote done");
    wrReg(5'd5, 8'h3C); wrReg(5'd6, 8'h00);
    wrReg(5'd0, 8'h06);
    rdExp(5'd0, 8'h02, "R9 tx bit self clears");
    rdExp(5'd4, 8'h01, "R9 tx status");
    rdExp(5'd7, 8'h42, "R9 tx done bit");
    wrReg(5'd7, 8'h02);
    rdExp(5'd7, 8'h40, "R4 partial clear");
    wrReg(5'd0, 8'h05);
    rdExp(5'd7, 8'h40, "R9 tx ignored while stopped");
    rdExp(5'd0, 8'h05, "R9 stopped cmd stored as written");
    wrReg(5'd0, 8'h02);

    // interrupt level
    wrReg(5'd15, 8'h02);
    chkIrq(1'b0, "R5 masked status");
    wrReg(5'd15, 8'h40);
    chkIrq(1'b1, "R5 enabled status");
    wrReg(5'd7, 8'h40);
    chkIrq(1'b0, "R5 cleared status drops irq");
    rdExp(5'd7, 8'h00, "R4 clear to zero");

    // two side effects on one edge
    wrReg(5'd0, 8'h0E);
    rdExp(5'd7, 8'h42, "R8 R9 same edge");
    rdExp(5'd0, 8'h0A, "R9 tx cleared with dma bit");
    chkIrq(1'b1, "R5 irq from same edge");
    wrReg(5'd0, 8'h82);
    rdExp(5'd15, 8'h40, "R10 mask readback");

    wait (expQ.size() == 0);
    @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule